// File: doc/BRIEF.md
# D-Channel Priority Access Arbiter

This block decides when a local HDLC controller may start sending on the shared upstream D-channel of a multi-terminal S-bus. It watches a stream of returned bits for a run of consecutive ones. The stream is either the echo channel or the upstream D-channel seen on the IOM-2 side. It grants the medium once that run reaches the threshold of the selected priority class and the controller asks for access. The controller asks by pulling its bus-access bit low.

While a frame is being sent, the block compares every transmitted D bit with the echo bit that comes back. On the first mismatch it withdraws the grant and raises a collision flag. After a frame completes without a collision, the block moves to a lowered priority level and requires one extra one in the run. It stays at that level until such a raised run has been seen. Clearing the collision-detection enable turns the whole scheme off, so that the grant simply follows the request.

All state advances only on a one-cycle bit strobe that marks each D-bit slot. Outputs are registered and change in the clock edge that takes the strobe.

Top module: `dch_prio_arbiter`

## Requirements
- R1: After reset, grant is 0, the collision flag is 0, the lowered-priority flag is 0 and the reported threshold is 8.
- R2: With `pri_hi`=0 the threshold is 8, and with `pri_hi`=1 it is 10. With the request held (`bac_n`=0), the grant rises after the strobe of the bit that brings the run of ones to the threshold, and not one bit earlier.
- R3: A 0 in the counted stream clears the run, so the full threshold of ones must follow before a grant.
- R4: While `bac_n`=1 (bus free, no request), no grant is given, however long the run of ones.
- R5: Once granted, the grant stays 1 while `bac_n`=0 and every echo bit equals the transmitted D bit. Between strobes no output changes.
- R6: In a granted slot where `echo` differs from `tx_d`, the grant goes to 0 and the collision flag goes to 1 after that strobe. The flag and the absence of grant hold until a strobe sees `bac_n`=1, and that strobe clears the flag.
- R7: A strobe with `bac_n`=1 during a grant ends the frame as a success. The grant drops, the lowered flag is set, and the threshold becomes the class value plus one (9 or 11).
- R8: While lowered and not requesting, the flag clears and the threshold returns to the class value after the strobe of the bit where the run reaches the raised threshold.
- R9: `src_iom`=0 counts ones on `echo`, and `src_iom`=1 counts ones on `iom_d`.
- R10: With `cd_en`=0, the grant equals the inverse of `bac_n` sampled at each strobe. No collision is flagged and the lowered flag is cleared.
- R11: The run count saturates at its maximum (15 by default) and never wraps to a small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per D-bit slot |
| cd_en | input | 1 | 1 enables collision detection and priority; 0 bypasses the scheme |
| pri_hi | input | 1 | Priority class: 0 selects threshold 8, 1 selects threshold 10 |
| src_iom | input | 1 | Counted stream: 0 echo channel, 1 IOM-2 upstream D |
| echo | input | 1 | Echo bit of the current slot |
| iom_d | input | 1 | IOM-2 upstream D bit of the current slot |
| tx_d | input | 1 | D bit the local controller transmits in the current slot |
| bac_n | input | 1 | Bus-access bit: 0 requests and holds access, 1 releases it |
| go | output | 1 | Grant: 1 means the controller may send |
| coll | output | 1 | Collision abort flag |
| lowered | output | 1 | 1 while at lowered priority |
| thr | output | CNT_W | Threshold currently in force |

## Verification
The bench aims at the exact bit in which the grant appears, for both classes and for the raised thresholds. A design off by one in the compare or in the register stage would grant a slot early or late. It breaks runs with a single zero, and it pushes the counter well past its maximum before a request. A design that wraps would then refuse a grant that is due. It forces a mismatch in mid-frame and keeps requesting, to catch a design that re-grants or drops the flag before release. It also drives echo and IOM bits in opposition, to catch a counter fed from the wrong stream.

// File: rtl/dch_arb_pkg.sv
// Shared types for the D-channel priority arbiter.
package dch_arb_pkg;
    // Access state: waiting for a run, sending a frame, or holding after a collision
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_SEND  = 2'd1,
        ARB_ABORT = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dch_run_counter.sv
// Counts consecutive ones of the selected bit stream, one step per bit strobe.
// Assumes bit_i is valid whenever bit_en_i is high. The count saturates at all-ones.
// The count after the current bit is also offered combinationally, so that a
// decision can be taken in the same slot.
module dch_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Next run length: a zero clears it, a one extends it up to saturation
    always_comb begin
        if (!bit_i)
            cnt_nxt_o = '0;
        else if (cnt_q == CNT_MAX)
            cnt_nxt_o = CNT_MAX;
        else
            cnt_nxt_o = cnt_q + 1'b1;
    end

    // Run register, advanced on each bit strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bit_en_i)
            cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;

    // R3: a zero bit leaves an empty run
    a_r3_zero_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !bit_i) |=> (cnt_o == '0));

    // R11: a full run stays full
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && bit_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/dch_thr_select.sv
// Forms the run threshold from the priority class and the lowered-priority flag.
// Assumes HI_THR + 1 fits in CNT_W bits.
module dch_thr_select #(
    parameter int CNT_W  = 4,
    parameter int LO_THR = 8,
    parameter int HI_THR = 10
) (
    input  logic             pri_hi_i,
    input  logic             lowered_i,
    output logic [CNT_W-1:0] thr_o
);
    localparam logic [CNT_W-1:0] LO_VAL = CNT_W'(LO_THR);
    localparam logic [CNT_W-1:0] HI_VAL = CNT_W'(HI_THR);

    // Class base value, plus one while lowered
    always_comb begin
        thr_o = (pri_hi_i ? HI_VAL : LO_VAL) + {{(CNT_W-1){1'b0}}, lowered_i};
    end
endmodule

// File: rtl/dch_access_fsm.sv
// Grant, collision and priority-level control for one local D-channel sender.
// Assumes the run count of the current slot (cnt_nxt_i) and the threshold are
// settled whenever bit_en_i is high. All outputs are registered and move only on
// strobes. A release of bac_n during a grant is taken before the echo compare.
module dch_access_fsm
    import dch_arb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en_i,
    input  logic             cd_en_i,
    input  logic             bac_n_i,
    input  logic             echo_i,
    input  logic             tx_d_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             go_o,
    output logic             coll_o,
    output logic             lowered_o
);
    arb_state_t st_q;
    logic       go_q, coll_q, low_q;
    logic       run_met;

    // Run condition for this slot
    assign run_met = (cnt_nxt_i >= thr_i);

    // Access state machine, evaluated once per bit slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ARB_IDLE;
            go_q   <= 1'b0;
            coll_q <= 1'b0;
            low_q  <= 1'b0;
        end else if (bit_en_i) begin
            if (!cd_en_i) begin
                st_q   <= ARB_IDLE;
                go_q   <= !bac_n_i;
                coll_q <= 1'b0;
                low_q  <= 1'b0;
            end else begin
                unique case (st_q)
                    ARB_IDLE: begin
                        coll_q <= 1'b0;
                        if (!bac_n_i && run_met) begin
                            st_q <= ARB_SEND;
                            go_q <= 1'b1;
                        end else begin
                            go_q <= 1'b0;
                            if (bac_n_i && low_q && run_met)
                                low_q <= 1'b0;
                        end
                    end
                    ARB_SEND: begin
                        if (bac_n_i) begin
                            st_q  <= ARB_IDLE;
                            go_q  <= 1'b0;
                            low_q <= 1'b1;
                        end else if (echo_i != tx_d_i) begin
                            st_q   <= ARB_ABORT;
                            go_q   <= 1'b0;
                            coll_q <= 1'b1;
                        end
                    end
                    ARB_ABORT: begin
                        go_q <= 1'b0;
                        if (bac_n_i) begin
                            st_q   <= ARB_IDLE;
                            coll_q <= 1'b0;
                        end
                    end
                    default: begin
                        st_q <= ARB_IDLE;
                        go_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign go_o      = go_q;
    assign coll_o    = coll_q;
    assign lowered_o = low_q;

    // R6: an aborted sender never holds the grant
    a_r6_coll_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
        coll_o |-> !go_o);

    // R2: no grant from idle on a short run
    a_r2_short_run_no_go: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && cd_en_i && st_q == ARB_IDLE && cnt_nxt_i < thr_i) |=> !go_o);

    // R7: a released frame lowers the priority and ends the grant
    a_r7_success_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && cd_en_i && st_q == ARB_SEND && bac_n_i) |=> (lowered_o && !go_o));

    // R5: outputs hold between strobes
    a_r5_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> ($stable(go_o) && $stable(coll_o) && $stable(lowered_o)));

    // R10: bypass follows the request bit
    a_r10_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !cd_en_i) |=> ((go_o == !$past(bac_n_i)) && !coll_o));
endmodule

// File: rtl/dch_prio_arbiter.sv
// Top of the D-channel priority access arbiter. It selects the counted stream,
// counts runs of ones, forms the class threshold and drives the grant and
// collision controller. Assumes a single local sender and a bit_en strobe once
// per D-bit slot, with the slot's inputs valid while the strobe is high.
module dch_prio_arbiter #(
    parameter int CNT_W  = 4,
    parameter int LO_THR = 8,
    parameter int HI_THR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             cd_en,
    input  logic             pri_hi,
    input  logic             src_iom,
    input  logic             echo,
    input  logic             iom_d,
    input  logic             tx_d,
    input  logic             bac_n,
    output logic             go,
    output logic             coll,
    output logic             lowered,
    output logic [CNT_W-1:0] thr
);
    logic             cnt_bit;
    logic [CNT_W-1:0] cnt_cur, cnt_nxt;

    // Stream selection for the run counter
    assign cnt_bit = src_iom ? iom_d : echo;

    dch_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en_i  (bit_en),
        .bit_i     (cnt_bit),
        .cnt_o     (cnt_cur),
        .cnt_nxt_o (cnt_nxt)
    );

    dch_thr_select #(.CNT_W(CNT_W), .LO_THR(LO_THR), .HI_THR(HI_THR)) u_thr (
        .pri_hi_i  (pri_hi),
        .lowered_i (lowered),
        .thr_o     (thr)
    );

    dch_access_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en_i  (bit_en),
        .cd_en_i   (cd_en),
        .bac_n_i   (bac_n),
        .echo_i    (echo),
        .tx_d_i    (tx_d),
        .cnt_nxt_i (cnt_nxt),
        .thr_i     (thr),
        .go_o      (go),
        .coll_o    (coll),
        .lowered_o (lowered)
    );

    // R4: a released bus bit leaves no grant after the slot
    a_r4_no_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cd_en && bac_n) |=> !go);

    // R8: the threshold is always the class value or one above it
    a_r8_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == (pri_hi ? CNT_W'(HI_THR) : CNT_W'(LO_THR)) + CNT_W'(lowered)));

    // R11: the count never exceeds the width
    a_r11_cnt_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(cnt_cur));
endmodule

// File: tb/sim_dch_prio_arbiter.sv
// Directed bench for the D-channel priority arbiter.
module sim_dch_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst_n, bit_en, cd_en, pri_hi, src_iom, echo, iom_d, tx_d, bac_n;
    logic       go, coll, lowered;
    logic [3:0] thr;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dch_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cd_en(cd_en), .pri_hi(pri_hi),
        .src_iom(src_iom), .echo(echo), .iom_d(iom_d), .tx_d(tx_d), .bac_n(bac_n),
        .go(go), .coll(coll), .lowered(lowered), .thr(thr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en, input logic hi, input logic src);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; cd_en = en; pri_hi = hi; src_iom = src;
        echo = 1'b0; iom_d = 1'b0; tx_d = 1'b0; bac_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic slot(input logic e, input logic i, input logic t, input logic b);
        @(negedge clk);
        echo = e; iom_d = i; tx_d = t; bac_n = b; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic ones(input int n, input logic b);
        for (int k = 0; k < n; k++) slot(1'b1, 1'b1, 1'b1, b);
    endtask

    task automatic t_reset;
        do_reset(1'b1, 1'b0, 1'b0);
        check("R1 go", go, 0);
        check("R1 coll", coll, 0);
        check("R1 lowered", lowered, 0);
        check("R1 thr", thr, 8);
    endtask

    task automatic t_class_low;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(7, 1'b0);
        check("R2 seven ones no go", go, 0);
        ones(1, 1'b0);
        check("R2 eighth one go", go, 1);
        slot(1'b0, 1'b0, 1'b0, 1'b0);
        slot(1'b1, 1'b1, 1'b1, 1'b0);
        slot(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 go held on matching echo", go, 1);
        repeat (5) @(negedge clk);
        check("R5 go stable between slots", go, 1);
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 go drops on release", go, 0);
        check("R7 lowered set", lowered, 1);
        check("R7 thr raised", thr, 9);
        ones(8, 1'b0);
        check("R7 eight ones not enough", go, 0);
        ones(1, 1'b0);
        check("R7 ninth one go", go, 1);
    endtask

    task automatic t_class_high;
        do_reset(1'b1, 1'b1, 1'b0);
        check("R2 class high thr", thr, 10);
        ones(9, 1'b0);
        check("R2 nine ones no go", go, 0);
        ones(1, 1'b0);
        check("R2 tenth one go", go, 1);
    endtask

    task automatic t_zero_breaks;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(5, 1'b0);
        slot(1'b0, 1'b0, 1'b0, 1'b0);
        ones(7, 1'b0);
        check("R3 run cleared by zero", go, 0);
        ones(1, 1'b0);
        check("R3 full run after zero", go, 1);
    endtask

    task automatic t_no_request;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(12, 1'b1);
        check("R4 no grant without request", go, 0);
    endtask

    task automatic t_collision;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(8, 1'b0);
        check("R6 granted before clash", go, 1);
        slot(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 go dropped on clash", go, 0);
        check("R6 coll raised", coll, 1);
        ones(10, 1'b0);
        check("R6 no regrant while held", go, 0);
        check("R6 coll held", coll, 1);
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 coll cleared on release", coll, 0);
        check("R6 not lowered after clash", lowered, 0);
    endtask

    task automatic t_return_normal;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(8, 1'b0);
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        ones(8, 1'b1);
        check("R8 still lowered at eight", lowered, 1);
        ones(1, 1'b1);
        check("R8 lowered cleared at nine", lowered, 0);
        check("R8 thr back to class", thr, 8);
    endtask

    task automatic t_source;
        do_reset(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) slot(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 iom stream counted", go, 1);
        do_reset(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) slot(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 echo ignored with iom source", go, 0);
    endtask

    task automatic t_bypass;
        do_reset(1'b0, 1'b0, 1'b0);
        slot(1'b0, 1'b0, 1'b0, 1'b0);
        check("R10 bypass grants at once", go, 1);
        slot(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 mismatch keeps go", go, 1);
        check("R10 no coll in bypass", coll, 0);
        slot(1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 release drops go", go, 0);
        check("R10 not lowered", lowered, 0);
    endtask

    task automatic t_saturate;
        do_reset(1'b1, 1'b0, 1'b0);
        ones(20, 1'b1);
        ones(1, 1'b0);
        check("R11 saturated run still grants", go, 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_class_low;
        t_class_high;
        t_zero_breaks;
        t_no_request;
        t_collision;
        t_return_normal;
        t_source;
        t_bypass;
        t_saturate;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule